// File: doc/BRIEF.md
# Flash Page and Burst Read Path

This block is the read-side datapath of a NOR-style flash device model. It holds a behavioural array organised as rows of sixteen words and serves reads in one of two modes. The mode is chosen by bit 15 of a configuration word. In page mode the block captures a whole row into a buffer. The low four address bits then pick any word of that row without a new address strobe. In burst mode the block captures a start address, waits a programmable number of clocks with the wait output high, and then streams consecutive words on consecutive clock edges. A fixed-length burst wraps inside its aligned group. A continuous burst counts straight through row boundaries.

A flag from the command logic tells the block whether the device is in array-read state. When the flag is low, the block outputs a supplied non-array word (status, identifier or similar) in place of array data. Burst timing is the same in both cases, and the same word repeats on every beat. All outputs are registered, and the reset is synchronous and active high. A program port fills the array word by word.

Top module: `flash_rd_path`

## Requirements
- R1: While `rst` is high, each clock edge clears `rd_data` to zero and drives `rd_oe` and `rd_wait` low.
- R2: With `cfg[15]`=1 (page mode), `rd_wait` is low. An edge with `ce` and `adv` high captures the row of `addr[9:4]`. Each later edge loads `rd_data` with the word of that row selected by `addr[3:0]` as sampled at that edge.
- R3: In page mode, once the row is captured, changes on `addr[3:0]` alone select among all sixteen buffered words, and changes on `addr[15:4]` without `adv` do not change the row.
- R4: In burst mode (`cfg[15]`=0), every edge with `ce` and `adv` high captures `addr` and restarts the burst. When the strobe is held over several edges, the address from the last such edge is used.
- R5: The latency field `cfg[13:11]` gives L clocks, with codes 0 and 1 treated as 2. The first word is loaded on the L-th edge after the capture edge. `rd_wait` is high on the capture edge and on every edge between it and the first word.
- R6: After the first word, one word is loaded on each following edge with `rd_wait` low, until the burst ends.
- R7: Length field `cfg[2:0]` code 1, 2 or 3 gives a burst of 4, 8 or 16 words. The address increments modulo the length inside its aligned group. After the last word, `rd_wait` returns high and `rd_data` holds.
- R8: Any other length code gives a continuous burst. The word address increments by one on every beat and crosses row boundaries.
- R9: With `arr_sel`=0, each data load (page-mode edge or burst beat) drives `nonarr_word` in place of array data. The burst timing is unchanged.
- R10: An edge with `ce` low aborts any burst and drives `rd_oe` and `rd_wait` low. When `ce` returns high without `adv`, no data beat occurs, and in burst mode `rd_wait` stays high.
- R11: `rd_oe` equals `ce` AND `oe` as sampled on the previous edge.
- R12: A `prog_en` edge writes `prog_data` to array word `prog_addr[9:0]`. Reads use `addr[9:0]` only, so higher address bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable, active high |
| adv | input | 1 | Address-valid strobe, active high |
| oe | input | 1 | Output enable, active high |
| addr | input | 16 | Word address |
| cfg | input | 16 | Read configuration: [15] page mode, [13:11] latency, [2:0] length |
| arr_sel | input | 1 | 1 = array-read state, 0 = non-array word |
| nonarr_word | input | 16 | Word driven during non-array reads |
| prog_en | input | 1 | Array word write strobe |
| prog_addr | input | 16 | Array word write address |
| prog_data | input | 16 | Array word write data |
| rd_data | output | 16 | Registered read data |
| rd_oe | output | 1 | Data bus drive enable (low = tristate) |
| rd_wait | output | 1 | High while burst data is not valid |

## Verification
Page-mode data is due one edge after the low address bits are presented, once the row has been captured by a strobe edge one edge earlier. `rd_oe` and abort effects are due on the edge right after `ce` or `oe` changes. A burst's first word is due on edge L counted from the capture edge, and each further word one edge later. The bench drives inputs on falling edges and reads outputs on the next falling edge, so every expectation is compared exactly half a period after the edge that makes it due.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  localparam int CFG_PAGE_BIT = 15;
  localparam int CFG_LAT_LSB  = 11;
  localparam int CFG_LEN_LSB  = 0;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LAT,
    PH_DATA,
    PH_DONE
  } phase_t;

  // Latency code to clock count; codes below two are raised to two.
  function automatic logic [3:0] lat_clocks(input logic [2:0] code);
    if (code < 3'd2) return 4'd2;
    return {1'b0, code};
  endfunction

  function automatic logic len_fixed(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
  endfunction

  function automatic int len_words(input logic [2:0] code);
    case (code)
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/flash_page_array.sv
module flash_page_array #(
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 16,
  parameter int ARR_PAGES  = 64,
  localparam int PG_AW     = $clog2(PAGE_WORDS),
  localparam int ROW_AW    = $clog2(ARR_PAGES),
  localparam int ROW_W     = PAGE_WORDS * DATA_W
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [PG_AW+ROW_AW-1:0]   wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ROW_AW-1:0]         rd_row,
  output logic [ROW_W-1:0]          rd_page
);

  logic [ROW_W-1:0] mem [ARR_PAGES];

  logic [ROW_AW-1:0] wr_row;
  logic [PG_AW-1:0]  wr_lane;

  assign wr_row  = wr_addr[PG_AW +: ROW_AW];
  assign wr_lane = wr_addr[PG_AW-1:0];

  // Per-lane write enables on a wide row, registered full-row read.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int w = 0; w < PAGE_WORDS; w++) begin
        if (wr_lane == PG_AW'(w)) begin
          mem[wr_row][w*DATA_W +: DATA_W] <= wr_data;
        end
      end
    end
    rd_page <= mem[rd_row];
  end

endmodule

// File: rtl/flash_addr_ctr.sv
module flash_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic [2:0]        len_code,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [ADDR_W-1:0] ptr_nxt
);

  logic [ADDR_W-1:0] wrap_mask;
  logic [ADDR_W-1:0] ptr_inc;
  logic [ADDR_W-1:0] ptr_step;

  always_comb begin
    case (len_code)
      3'd1:    wrap_mask = ADDR_W'(3);
      3'd2:    wrap_mask = ADDR_W'(7);
      3'd3:    wrap_mask = ADDR_W'(15);
      default: wrap_mask = '1;
    endcase
    ptr_inc  = ptr_q + ADDR_W'(1);
    ptr_step = (ptr_q & ~wrap_mask) | (ptr_inc & wrap_mask);
    if (load)      ptr_nxt = load_addr;
    else if (step) ptr_nxt = ptr_step;
    else           ptr_nxt = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_nxt;
  end

endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq
  import flash_rd_pkg::*;
#(
  parameter int PAGE_WORDS = 16,
  localparam int BEAT_W    = $clog2(PAGE_WORDS) + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       start,
  input  logic [2:0] lat_code,
  input  logic [2:0] len_code,
  output logic       beat
);

  phase_t            phase_q;
  logic [3:0]        cnt_q;
  logic [BEAT_W-1:0] beats_q;
  logic [BEAT_W-1:0] beats_inc;
  logic [BEAT_W-1:0] burst_n;
  logic              fixed;

  always_comb begin
    fixed     = len_fixed(len_code);
    burst_n   = BEAT_W'(len_words(len_code));
    beats_inc = beats_q + BEAT_W'(1);
    beat      = en && !start &&
                (((phase_q == PH_LAT) && (cnt_q == 4'd1)) || (phase_q == PH_DATA));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      beats_q <= '0;
    end else if (start) begin
      phase_q <= PH_LAT;
      cnt_q   <= lat_clocks(lat_code);
      beats_q <= '0;
    end else if (beat) begin
      beats_q <= beats_inc;
      if (fixed && (beats_inc == burst_n)) phase_q <= PH_DONE;
      else                                 phase_q <= PH_DATA;
    end else if (phase_q == PH_LAT) begin
      cnt_q <= cnt_q - 4'd1;
    end
  end

endmodule

// File: rtl/flash_rd_out.sv
module flash_rd_out #(
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 16,
  localparam int PG_AW     = $clog2(PAGE_WORDS),
  localparam int ROW_W     = PAGE_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              oe,
  input  logic              page_mode,
  input  logic              beat,
  input  logic              arr_sel,
  input  logic [ROW_W-1:0]  page_bus,
  input  logic [PG_AW-1:0]  word_idx,
  input  logic [DATA_W-1:0] nonarr_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              rd_wait
);

  logic [DATA_W-1:0] sel_word;

  always_comb begin
    if (arr_sel) sel_word = page_bus[word_idx*DATA_W +: DATA_W];
    else         sel_word = nonarr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_oe   <= 1'b0;
      rd_wait <= 1'b0;
    end else begin
      rd_oe <= ce && oe;
      if (!ce) begin
        rd_wait <= 1'b0;
      end else if (page_mode) begin
        rd_wait <= 1'b0;
        rd_data <= sel_word;
      end else begin
        rd_wait <= !beat;
        if (beat) rd_data <= sel_word;
      end
    end
  end

endmodule

// File: rtl/flash_rd_path.sv
module flash_rd_path
  import flash_rd_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 16,
  parameter int PAGE_WORDS = 16,
  parameter int ARR_PAGES  = 64,
  localparam int PG_AW     = $clog2(PAGE_WORDS),
  localparam int ROW_AW    = $clog2(ARR_PAGES),
  localparam int ROW_W     = PAGE_WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              adv,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       cfg,
  input  logic              arr_sel,
  input  logic [DATA_W-1:0] nonarr_word,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              rd_wait
);

  logic              page_mode;
  logic [2:0]        lat_code;
  logic [2:0]        len_code;
  logic              strobe;
  logic              burst_start;
  logic              burst_en;
  logic              beat;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_nxt;
  logic [ROW_W-1:0]  page_q;
  logic [PG_AW-1:0]  word_idx;
  logic              cfg_unused;
  logic              prog_unused;

  assign page_mode   = cfg[CFG_PAGE_BIT];
  assign lat_code    = cfg[CFG_LAT_LSB +: 3];
  assign len_code    = cfg[CFG_LEN_LSB +: 3];
  assign strobe      = ce && adv;
  assign burst_en    = ce && !page_mode;
  assign burst_start = strobe && !page_mode;
  assign word_idx    = page_mode ? addr[PG_AW-1:0] : ptr_q[PG_AW-1:0];
  assign cfg_unused  = ^{cfg[14], cfg[10:3]};
  assign prog_unused = ^prog_addr[ADDR_W-1:PG_AW+ROW_AW];

  flash_addr_ctr #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (strobe),
    .load_addr (addr),
    .step      (beat),
    .len_code  (len_code),
    .ptr_q     (ptr_q),
    .ptr_nxt   (ptr_nxt)
  );

  flash_burst_seq #(
    .PAGE_WORDS (PAGE_WORDS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .en       (burst_en),
    .start    (burst_start),
    .lat_code (lat_code),
    .len_code (len_code),
    .beat     (beat)
  );

  flash_page_array #(
    .DATA_W     (DATA_W),
    .PAGE_WORDS (PAGE_WORDS),
    .ARR_PAGES  (ARR_PAGES)
  ) u_array (
    .clk     (clk),
    .wr_en   (prog_en),
    .wr_addr (prog_addr[PG_AW+ROW_AW-1:0]),
    .wr_data (prog_data),
    .rd_row  (ptr_nxt[PG_AW +: ROW_AW]),
    .rd_page (page_q)
  );

  flash_rd_out #(
    .DATA_W     (DATA_W),
    .PAGE_WORDS (PAGE_WORDS)
  ) u_out (
    .clk         (clk),
    .rst         (rst),
    .ce          (ce),
    .oe          (oe),
    .page_mode   (page_mode),
    .beat        (beat),
    .arr_sel     (arr_sel),
    .page_bus    (page_q),
    .word_idx    (word_idx),
    .nonarr_word (nonarr_word),
    .rd_data     (rd_data),
    .rd_oe       (rd_oe),
    .rd_wait     (rd_wait)
  );

endmodule

// File: rtl/flash_rd_path_chk.sv
module flash_rd_path_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic              adv,
  input logic              oe,
  input logic [15:0]       cfg,
  input logic              arr_sel,
  input logic [DATA_W-1:0] nonarr_word,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_oe,
  input logic              rd_wait
);

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0 && !rd_oe && !rd_wait));

  a_r2_page_no_wait: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ce && cfg[15])) |-> !rd_wait);

  a_r5_wait_on_capture: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ce && adv && !cfg[15])) |-> rd_wait);

  a_r5_wait_after_capture: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 2) && $past(!rst) && $past(ce && adv && !cfg[15], 2) &&
     $past(ce && !cfg[15])) |-> rd_wait);

  a_r7_hold_while_wait: assert property (@(posedge clk) disable iff (rst)
    rd_wait |-> $stable(rd_data));

  a_r9_nonarray_word: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ce && !arr_sel) && !rd_wait) |-> rd_data == $past(nonarr_word));

  a_r10_ce_low_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(ce)) |-> (!rd_oe && !rd_wait));

  a_r11_oe_follows: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(ce && oe)) |-> rd_oe);

endmodule

bind flash_rd_path flash_rd_path_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ce          (ce),
  .adv         (adv),
  .oe          (oe),
  .cfg         (cfg),
  .arr_sel     (arr_sel),
  .nonarr_word (nonarr_word),
  .rd_data     (rd_data),
  .rd_oe       (rd_oe),
  .rd_wait     (rd_wait)
);

// File: tb/flash_rd_path_test.sv
module flash_rd_path_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] NONARR = 16'hBEEF;

  typedef struct packed {
    logic [2:0]  lat;
    logic [2:0]  len;
    logic [15:0] addr;
    logic        arr;
    logic [4:0]  nbeats;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{3'd2, 3'd1, 16'h0012, 1'b1, 5'd4},
    '{3'd5, 3'd2, 16'h0135, 1'b1, 5'd8},
    '{3'd7, 3'd3, 16'h02AB, 1'b1, 5'd16},
    '{3'd0, 3'd7, 16'h03FA, 1'b1, 5'd12},
    '{3'd3, 3'd1, 16'h0040, 1'b0, 5'd4},
    '{3'd4, 3'd0, 16'h07FE, 1'b1, 5'd6},
    '{3'd6, 3'd2, 16'h1407, 1'b1, 5'd8}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic        adv = 1'b0;
  logic        oe = 1'b1;
  logic [15:0] addr = '0;
  logic [15:0] cfg = 16'h8000;
  logic        arr_sel = 1'b1;
  logic [15:0] nonarr_word = NONARR;
  logic        prog_en = 1'b0;
  logic [15:0] prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic [15:0] rd_data;
  logic        rd_oe;
  logic        rd_wait;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  flash_rd_path uut (
    .clk(clk), .rst(rst), .ce(ce), .adv(adv), .oe(oe), .addr(addr), .cfg(cfg),
    .arr_sel(arr_sel), .nonarr_word(nonarr_word), .prog_en(prog_en),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .rd_data(rd_data), .rd_oe(rd_oe), .rd_wait(rd_wait)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] fword(input logic [15:0] a);
    return {a[5:0], a[9:0]} ^ 16'h9C3B;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_burst(input vec_t v);
    int L;
    bit fixed;
    logic [15:0] mask;
    logic [15:0] a;
    logic [15:0] ev;
    string tag;
    L = (v.lat < 3'd2) ? 2 : int'(v.lat);
    fixed = (v.len == 3'd1) || (v.len == 3'd2) || (v.len == 3'd3);
    mask = fixed ? ((16'd4 << (v.len - 3'd1)) - 16'd1) : 16'hFFFF;
    tag = !v.arr ? "R9 non-array beat" : (fixed ? "R7 wrap data" : "R8 linear data");
    ev = '0;
    @(negedge clk);
    ce = 1'b1; adv = 1'b1; addr = v.addr; arr_sel = v.arr;
    cfg = {1'b0, 1'b0, v.lat, 8'h00, v.len};
    @(negedge clk);
    adv = 1'b0; addr = 16'hFFFF;
    chk("R5 wait on capture edge", {15'd0, rd_wait}, 16'd1);
    for (int k = 1; k < L + int'(v.nbeats); k++) begin
      @(negedge clk);
      if (k < L) begin
        chk("R5 wait during latency", {15'd0, rd_wait}, 16'd1);
      end else begin
        a  = (v.addr & ~mask) | (16'(v.addr + 16'(k - L)) & mask);
        ev = v.arr ? fword(a) : NONARR;
        chk("R6 wait low on beat", {15'd0, rd_wait}, 16'd0);
        chk(tag, rd_data, ev);
      end
    end
    if (fixed) begin
      @(negedge clk);
      chk("R7 wait after last word", {15'd0, rd_wait}, 16'd1);
      chk("R7 data held after end", rd_data, ev);
    end
    ce = 1'b0;
    @(negedge clk);
    chk("R10 bus off after ce low", {15'd0, rd_oe}, 16'd0);
    chk("R10 wait low after ce low", {15'd0, rd_wait}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset data", rd_data, 16'h0000);
    chk("R1 reset oe", {15'd0, rd_oe}, 16'd0);
    chk("R1 reset wait", {15'd0, rd_wait}, 16'd0);
    rst = 1'b0;

    // R12: fill the array through the program port
    for (int i = 0; i < 1024; i++) begin
      prog_en = 1'b1; prog_addr = 16'(i); prog_data = fword(16'(i));
      @(negedge clk);
    end
    prog_en = 1'b0;

    // Table of burst vectors
    for (int n = 0; n < NVEC; n++) run_burst(VECS[n]);

    // R2 / R3: page mode
    cfg = 16'h8000; arr_sel = 1'b1;
    ce = 1'b1; adv = 1'b1; addr = 16'h0230;
    @(negedge clk);
    adv = 1'b0;
    @(negedge clk);
    chk("R2 page first word", rd_data, fword(16'h0230));
    chk("R2 page wait low", {15'd0, rd_wait}, 16'd0);
    for (int i = 15; i >= 0; i--) begin
      addr = {12'h023, 4'(i)};
      @(negedge clk);
      chk("R3 page word select", rd_data, fword({12'h023, 4'(i)}));
    end
    addr = 16'h0557;
    @(negedge clk);
    chk("R3 row kept without strobe", rd_data, fword(16'h0237));
    arr_sel = 1'b0;
    @(negedge clk);
    chk("R9 page non-array word", rd_data, NONARR);
    arr_sel = 1'b1;
    oe = 1'b0;
    @(negedge clk);
    chk("R11 oe low disables bus", {15'd0, rd_oe}, 16'd0);
    oe = 1'b1;
    @(negedge clk);
    chk("R11 oe high enables bus", {15'd0, rd_oe}, 16'd1);

    // R4: strobe held over two edges, last address wins
    ce = 1'b0;
    @(negedge clk);
    cfg = {2'b00, 3'd3, 8'h00, 3'd7};
    ce = 1'b1; adv = 1'b1; addr = 16'h0100;
    @(negedge clk);
    addr = 16'h0155;
    @(negedge clk);
    adv = 1'b0; addr = 16'hFFFF;
    @(negedge clk);
    chk("R4 wait after restart", {15'd0, rd_wait}, 16'd1);
    @(negedge clk);
    chk("R4 wait after restart", {15'd0, rd_wait}, 16'd1);
    @(negedge clk);
    chk("R4 last latched address", rd_data, fword(16'h0155));
    @(negedge clk);
    chk("R4 next word", rd_data, fword(16'h0156));

    // R10: abort mid-burst, resume without strobe
    ce = 1'b0;
    @(negedge clk);
    chk("R10 abort oe", {15'd0, rd_oe}, 16'd0);
    chk("R10 abort wait", {15'd0, rd_wait}, 16'd0);
    ce = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 no beat without strobe", {15'd0, rd_wait}, 16'd1);
    end
    chk("R10 data not advanced", rd_data, fword(16'h0156));

    // R1: reset in the middle of a burst
    adv = 1'b1; addr = 16'h0020;
    @(negedge clk);
    adv = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset data", rd_data, 16'h0000);
    chk("R1 mid-run reset wait", {15'd0, rd_wait}, 16'd0);
    chk("R1 mid-run reset oe", {15'd0, rd_oe}, 16'd0);
    rst = 1'b0; ce = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule